// File: doc/BRIEF.md
# Flash Controller Option Lock and Status Register Logic

This block is the register-side control logic of an embedded flash controller. It holds the lock that guards the option-byte registers and the status word that software polls. It also holds the program/erase settings fields. A flash operation engine reports four events to it: an operation was requested, the operation finished, an error occurred, and the first programming word was accepted. Two suspend-request bits hold off new operations.

Software opens the option lock by writing two fixed key values to the key register. The writes must come back to back and in the right order. A wrong sequence freezes the lock until the next reset. The block forwards start requests to the engine only when no suspend is active and no operation is running. While a programming sequence is under way, it freezes the settings fields against writes.

The register bus is a plain word-addressed write port with a combinational read port. Word 0 is the key register, word 1 is the control register and word 2 is the status register. Every other word reads as zero.

Top module: `flash_regif_top`

## Requirements
- R1: The option lock (`opt_locked`) opens only after two consecutive writes to word 0: 0x08192A3B first, then 0x4C5D6E7F. It drops in the cycle after the second write's clock edge.
- R2: A wrong value, the keys in the wrong order, or a repeated first key leaves the lock set. After that, any further key writes are ignored until reset.
- R3: Writing 1 to control bit 31 re-engages the lock. Control bit 31 reads back the lock state (1 = locked). After a re-lock, a correct key pair unlocks again.
- R4: Status bit 19 (suspend done) equals the OR of the two `susp_req` bits, registered once. It is 0 only when both bits were 0.
- R5: `op_start` never pulses while suspend done is 1. A request made during a suspend is held and issued once, after suspend done falls and busy is 0.
- R6: Status bit 16 (busy) is set the cycle after `op_start`. It clears after `op_done` or `op_err`.
- R7: Status bit 18 (configuration busy) is set by `first_word` and cleared by `op_done` or `op_err`. The output `cfg_we` is its inverse.
- R8: The control settings are program enable (bit 0), page erase (bit 1), mass erase (bit 2) and page number (bits 9:3). A control write updates them only while configuration busy is 0; otherwise they keep their values.
- R9: Status bit 0 (end of operation, set by `op_done`) and bit 1 (operation error, set by `op_err`) are sticky. Writing 1 to a bit clears it; writing 0 leaves it unchanged.
- R10: If a hardware set and a write-1 clear hit the same sticky flag in the same cycle, the flag ends up set.
- R11: Status bit 15 (option validity error) is set by an `opt_load_fail` pulse and cleared by writing 1. Reset clears it, and a new failure pulse after reset sets it again.
- R12: Status bits 31:20, 17 and 14:2 read as zero. Word 0 and unmapped words read as zero.
- R13: After reset the lock is set, the settings are zero, the status word is zero, `cfg_we` is 1 and `op_start` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| op_start_req | input | 1 | Software request to begin a flash operation |
| op_done | input | 1 | Engine reports operation complete |
| op_err | input | 1 | Engine reports an error, aborting the operation |
| first_word | input | 1 | Engine accepted the first programming word |
| susp_req | input | 2 | Two independent suspend-request bits |
| opt_load_fail | input | 1 | Pulse: loaded option bits may be invalid |
| opt_locked | output | 1 | Option registers locked |
| op_start | output | 1 | Gated start strobe to the engine |
| cfg_we | output | 1 | Program/erase settings may be changed |

## Verification
The key sequence is tried with several patterns: the correct pair, the reversed pair, a repeated first key, and a stray value. These are followed by a correct pair, which separates "still waiting" from "frozen". Randomised two- and three-write sequences drawn mostly from the two keys cover the mixed orders. Random suspend-bit pairs separate OR behaviour from AND or single-bit behaviour. A start request placed inside a suspend window shows whether the request is dropped, issued early, or issued once. Set-versus-clear collisions, 0-writes and 1-writes to the status word, and random settings writes with configuration busy either high or low separate the sticky, priority and write-guard rules.

// File: rtl/flash_regif_pkg.sv
package flash_regif_pkg;

    localparam int unsigned DATA_W = 32;
    localparam int unsigned PAGE_W = 7;
    localparam int unsigned SET_W  = PAGE_W + 3;

    // status word bit positions
    localparam int unsigned ST_EOP  = 0;
    localparam int unsigned ST_ERR  = 1;
    localparam int unsigned ST_OPTV = 15;
    localparam int unsigned ST_BSY  = 16;
    localparam int unsigned ST_CFG  = 18;
    localparam int unsigned ST_SUSP = 19;

    // control word lock bit
    localparam int unsigned CT_LOCK = 31;

    typedef enum logic [1:0] {
        LK_IDLE,
        LK_HALF,
        LK_OPEN,
        LK_FROZEN
    } lock_st_e;

    typedef struct packed {
        logic [PAGE_W-1:0] page;
        logic              mass_erase;
        logic              page_erase;
        logic              prog_en;
    } settings_t;

    typedef struct packed {
        logic susp_done;
        logic cfg_busy;
        logic busy;
        logic optverr;
        logic op_err;
        logic eop;
    } status_t;

    function automatic logic [DATA_W-1:0] pack_status(input status_t s);
        logic [DATA_W-1:0] w;
        w          = '0;
        w[ST_EOP]  = s.eop;
        w[ST_ERR]  = s.op_err;
        w[ST_OPTV] = s.optverr;
        w[ST_BSY]  = s.busy;
        w[ST_CFG]  = s.cfg_busy;
        w[ST_SUSP] = s.susp_done;
        return w;
    endfunction

    function automatic logic [DATA_W-1:0] pack_ctrl(input logic locked, input settings_t st);
        logic [DATA_W-1:0] w;
        w             = '0;
        w[SET_W-1:0]  = st;
        w[CT_LOCK]    = locked;
        return w;
    endfunction

endpackage

// File: rtl/flash_key_lock.sv
module flash_key_lock
    import flash_regif_pkg::*;
#(
    parameter logic [DATA_W-1:0] KEY_A = 32'h0819_2A3B,
    parameter logic [DATA_W-1:0] KEY_B = 32'h4C5D_6E7F
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              key_wr,
    input  logic [DATA_W-1:0] key_data,
    input  logic              relock,
    output logic              locked
);

    lock_st_e st_q, st_d;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            LK_IDLE: begin
                if (key_wr) st_d = (key_data == KEY_A) ? LK_HALF : LK_FROZEN;
            end
            LK_HALF: begin
                if (key_wr)      st_d = (key_data == KEY_B) ? LK_OPEN : LK_FROZEN;
                else if (relock) st_d = LK_IDLE;
            end
            LK_OPEN: begin
                if (relock) st_d = LK_IDLE;
            end
            LK_FROZEN: st_d = LK_FROZEN;
            default:   st_d = LK_FROZEN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= LK_IDLE;
        else     st_q <= st_d;
    end

    assign locked = (st_q != LK_OPEN);

endmodule

// File: rtl/flash_settings_reg.sv
module flash_settings_reg
    import flash_regif_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      wr,
    input  settings_t wdata,
    input  logic      cfg_busy,
    output settings_t settings
);

    settings_t set_q;

    always_ff @(posedge clk) begin
        if (rst)                  set_q <= '0;
        else if (wr && !cfg_busy) set_q <= wdata;
    end

    assign settings = set_q;

endmodule

// File: rtl/flash_status_flags.sv
module flash_status_flags
    import flash_regif_pkg::*;
#(
    parameter int unsigned SUSP_N = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [SUSP_N-1:0] susp_req,
    input  logic              start_req,
    input  logic              op_done,
    input  logic              op_err,
    input  logic              first_word,
    input  logic              opt_load_fail,
    input  logic              clr_eop,
    input  logic              clr_err,
    input  logic              clr_optv,
    output status_t           stat,
    output logic              op_start
);

    status_t s_q;
    logic    pend_q;
    logic    finish;
    logic    issue;

    assign finish = op_done | op_err;
    assign issue  = (start_req | pend_q) & ~s_q.susp_done & ~s_q.busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q    <= '0;
            pend_q <= 1'b0;
        end else begin
            s_q.susp_done <= |susp_req;

            if (issue)          pend_q <= 1'b0;
            else if (start_req) pend_q <= 1'b1;

            if (finish)     s_q.busy <= 1'b0;
            else if (issue) s_q.busy <= 1'b1;

            if (finish)          s_q.cfg_busy <= 1'b0;
            else if (first_word) s_q.cfg_busy <= 1'b1;

            // hardware set has priority over a clear write
            if (op_done)      s_q.eop <= 1'b1;
            else if (clr_eop) s_q.eop <= 1'b0;

            if (op_err)       s_q.op_err <= 1'b1;
            else if (clr_err) s_q.op_err <= 1'b0;

            if (opt_load_fail) s_q.optverr <= 1'b1;
            else if (clr_optv) s_q.optverr <= 1'b0;
        end
    end

    assign stat     = s_q;
    assign op_start = issue;

endmodule

// File: rtl/flash_regif_top.sv
module flash_regif_top
    import flash_regif_pkg::*;
#(
    parameter int unsigned       ADDR_W   = 4,
    parameter logic [DATA_W-1:0] KEY_A    = 32'h0819_2A3B,
    parameter logic [DATA_W-1:0] KEY_B    = 32'h4C5D_6E7F,
    parameter int unsigned       KEY_IDX  = 0,
    parameter int unsigned       CTRL_IDX = 1,
    parameter int unsigned       STAT_IDX = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_we,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              op_start_req,
    input  logic              op_done,
    input  logic              op_err,
    input  logic              first_word,
    input  logic [1:0]        susp_req,
    input  logic              opt_load_fail,
    output logic              opt_locked,
    output logic              op_start,
    output logic              cfg_we
);

    localparam logic [ADDR_W-1:0] A_KEY  = ADDR_W'(KEY_IDX);
    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(CTRL_IDX);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(STAT_IDX);

    logic      key_wr, ctrl_wr, stat_wr, relock;
    logic      clr_eop, clr_err, clr_optv;
    status_t   stat;
    settings_t settings;
    logic      unused_wdata;

    assign key_wr   = bus_we && (bus_addr == A_KEY);
    assign ctrl_wr  = bus_we && (bus_addr == A_CTRL);
    assign stat_wr  = bus_we && (bus_addr == A_STAT);
    assign relock   = ctrl_wr && bus_wdata[CT_LOCK];
    assign clr_eop  = stat_wr && bus_wdata[ST_EOP];
    assign clr_err  = stat_wr && bus_wdata[ST_ERR];
    assign clr_optv = stat_wr && bus_wdata[ST_OPTV];

    assign unused_wdata = ^bus_wdata[CT_LOCK-1:SET_W];

    flash_key_lock #(
        .KEY_A (KEY_A),
        .KEY_B (KEY_B)
    ) u_lock (
        .clk      (clk),
        .rst      (rst),
        .key_wr   (key_wr),
        .key_data (bus_wdata),
        .relock   (relock),
        .locked   (opt_locked)
    );

    flash_settings_reg u_settings (
        .clk      (clk),
        .rst      (rst),
        .wr       (ctrl_wr),
        .wdata    (settings_t'(bus_wdata[SET_W-1:0])),
        .cfg_busy (stat.cfg_busy),
        .settings (settings)
    );

    flash_status_flags #(
        .SUSP_N (2)
    ) u_flags (
        .clk           (clk),
        .rst           (rst),
        .susp_req      (susp_req),
        .start_req     (op_start_req),
        .op_done       (op_done),
        .op_err        (op_err),
        .first_word    (first_word),
        .opt_load_fail (opt_load_fail),
        .clr_eop       (clr_eop),
        .clr_err       (clr_err),
        .clr_optv      (clr_optv),
        .stat          (stat),
        .op_start      (op_start)
    );

    assign cfg_we = ~stat.cfg_busy;

    always_comb begin
        if (bus_addr == A_CTRL)      bus_rdata = pack_ctrl(opt_locked, settings);
        else if (bus_addr == A_STAT) bus_rdata = pack_status(stat);
        else                         bus_rdata = '0;
    end

endmodule

// File: rtl/flash_regif_chk.sv
module flash_regif_chk #(
    parameter int unsigned  ADDR_W   = 4,
    parameter logic [31:0]  KEY_B    = 32'h4C5D_6E7F,
    parameter int unsigned  STAT_IDX = 2
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_wdata,
    input logic [31:0]       bus_rdata,
    input logic              key_wr,
    input logic              opt_locked,
    input logic [1:0]        susp_req,
    input logic              susp_flag,
    input logic              op_start,
    input logic              op_done,
    input logic              op_err,
    input logic              busy,
    input logic              cfg_busy,
    input logic [9:0]        settings,
    input logic              eop,
    input logic              clr_eop
);

    logic past_ok;
    always_ff @(posedge clk) begin
        if (rst) past_ok <= 1'b0;
        else     past_ok <= 1'b1;
    end

    // R1
    unlock_key_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(opt_locked) |-> $past(key_wr && (bus_wdata == KEY_B)));

    // R4
    susp_follow_chk: assert property (@(posedge clk) disable iff (rst)
        past_ok |-> (susp_flag == $past(|susp_req)));

    // R5
    no_start_in_susp_chk: assert property (@(posedge clk) disable iff (rst)
        !(op_start && susp_flag));

    // R6
    busy_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (op_done || op_err) |=> !busy);

    // R8
    settings_hold_chk: assert property (@(posedge clk) disable iff (rst)
        cfg_busy |=> $stable(settings));

    // R9
    eop_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (eop && !clr_eop) |=> eop);

    // R10
    eop_set_wins_chk: assert property (@(posedge clk) disable iff (rst)
        op_done |=> eop);

    // R12
    reserved_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == ADDR_W'(STAT_IDX)) |-> (bus_rdata[31:20] == 12'h0 && !bus_rdata[17]));

endmodule

bind flash_regif_top flash_regif_chk #(
    .ADDR_W   (ADDR_W),
    .KEY_B    (KEY_B),
    .STAT_IDX (STAT_IDX)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .key_wr     (key_wr),
    .opt_locked (opt_locked),
    .susp_req   (susp_req),
    .susp_flag  (stat.susp_done),
    .op_start   (op_start),
    .op_done    (op_done),
    .op_err     (op_err),
    .busy       (stat.busy),
    .cfg_busy   (stat.cfg_busy),
    .settings   (settings),
    .eop        (stat.eop),
    .clr_eop    (clr_eop)
);

// File: tb/test_flash_regif_top.sv
`timescale 1ns/1ps
module test_flash_regif_top;

    localparam logic [31:0] KA = 32'h0819_2A3B;
    localparam logic [31:0] KB = 32'h4C5D_6E7F;
    localparam logic [3:0]  W_KEY = 4'd0, W_CTRL = 4'd1, W_STAT = 4'd2;
    localparam logic [31:0] USED_MASK = 32'h000D_8003;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_rdata;
    logic        op_start_req = 1'b0, op_done = 1'b0, op_err = 1'b0, first_word = 1'b0;
    logic [1:0]  susp_req = '0;
    logic        opt_load_fail = 1'b0;
    logic        opt_locked, op_start, cfg_we;

    int n_vec = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    flash_regif_top i_flash_regif_top (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .bus_rdata(bus_rdata), .op_start_req(op_start_req),
        .op_done(op_done), .op_err(op_err), .first_word(first_word),
        .susp_req(susp_req), .opt_load_fail(opt_load_fail),
        .opt_locked(opt_locked), .op_start(op_start), .cfg_we(cfg_we)
    );

    function automatic int lk_next(int st, logic [31:0] v);
        if (st == 0) return (v == KA) ? 1 : 3;
        if (st == 1) return (v == KB) ? 2 : 3;
        return st;
    endfunction

    function automatic logic [31:0] exp_stat(bit su, bit cf, bit bs, bit ov, bit er, bit eo);
        logic [31:0] w = '0;
        w[19] = su; w[18] = cf; w[16] = bs; w[15] = ov; w[1] = er; w[0] = eo;
        return w;
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic wr(logic [3:0] a, logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        tick();
        bus_we = 1'b0;
    endtask

    task automatic rd(logic [3:0] a, output logic [31:0] v);
        bus_addr = a; #1; v = bus_rdata;
    endtask

    task automatic do_reset();
        rst = 1'b1; tick(); tick(); rst = 1'b0;
    endtask

    task automatic report();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            report();
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        logic [9:0]  set_exp;
        void'($urandom(32'h5EED_1234));
        #1;
        do_reset();

        // R13 reset state
        rd(W_CTRL, v); chk("R13 ctrl", v, 32'h8000_0000);
        rd(W_STAT, v); chk("R13 stat", v, 32'h0);
        chk("R13 lock/cfg_we/start", {29'b0, opt_locked, cfg_we, op_start}, 32'h6);

        // R1 correct pair
        wr(W_KEY, KA); chk("R1 after first key", {31'b0, opt_locked}, 32'h1);
        wr(W_KEY, KB); chk("R1 after second key", {31'b0, opt_locked}, 32'h0);
        rd(W_CTRL, v); chk("R3 ctrl lock bit open", {31'b0, v[31]}, 32'h0);

        // R3 relock and reopen
        wr(W_CTRL, 32'h8000_0000); chk("R3 relocked", {31'b0, opt_locked}, 32'h1);
        wr(W_KEY, 32'h0); // no: this would freeze; verify R2 below instead
        wr(W_KEY, KA); wr(W_KEY, KB);
        chk("R2 frozen after stray value", {31'b0, opt_locked}, 32'h1);
        do_reset();
        wr(W_KEY, KA); wr(W_KEY, KB);
        wr(W_CTRL, 32'h8000_0000);
        wr(W_KEY, KA); wr(W_KEY, KB);
        chk("R3 reopen after relock", {31'b0, opt_locked}, 32'h0);

        // R2 reversed order then correct pair
        do_reset();
        wr(W_KEY, KB); wr(W_KEY, KA); wr(W_KEY, KA); wr(W_KEY, KB);
        chk("R2 reversed then correct", {31'b0, opt_locked}, 32'h1);
        // R2 repeated first key
        do_reset();
        wr(W_KEY, KA); wr(W_KEY, KA); wr(W_KEY, KB);
        chk("R2 repeated first key", {31'b0, opt_locked}, 32'h1);

        // R1/R2 random key sequences
        for (int t = 0; t < 30; t++) begin
            int st;
            int n;
            do_reset();
            st = 0;
            n = 2 + int'($urandom % 2);
            for (int i = 0; i < n; i++) begin
                logic [31:0] kv;
                int r;
                r = int'($urandom % 5);
                kv = (r < 2) ? KA : (r < 4) ? KB : $urandom;
                st = lk_next(st, kv);
                wr(W_KEY, kv);
                chk("R1 R2 random key seq", {31'b0, opt_locked}, {31'b0, (st != 2)});
            end
        end

        // R4 random suspend pairs, R12 reserved bits
        do_reset();
        for (int t = 0; t < 24; t++) begin
            logic [1:0] s;
            s = 2'($urandom);
            susp_req = s;
            tick();
            rd(W_STAT, v);
            chk("R4 suspend flag", {31'b0, v[19]}, {31'b0, |s});
            chk("R12 reserved status bits", v & ~USED_MASK, 32'h0);
        end
        susp_req = 2'b00; tick();

        // R5 held start
        susp_req = 2'b01; tick();
        op_start_req = 1'b1; #1;
        chk("R5 no start while suspended", {31'b0, op_start}, 32'h0);
        tick(); op_start_req = 1'b0; #1;
        chk("R5 pending held", {31'b0, op_start}, 32'h0);
        susp_req = 2'b00; tick();
        chk("R5 issued after suspend clears", {31'b0, op_start}, 32'h1);
        tick();
        chk("R5 issued once", {31'b0, op_start}, 32'h0);
        rd(W_STAT, v); chk("R6 busy set", v, exp_stat(0,0,1,0,0,0));
        op_done = 1'b1; tick(); op_done = 1'b0;
        rd(W_STAT, v); chk("R6 busy cleared by done, R9 eop", v, exp_stat(0,0,0,0,0,1));

        op_start_req = 1'b1; #1;
        chk("R5 direct start", {31'b0, op_start}, 32'h1);
        tick(); op_start_req = 1'b0;
        op_err = 1'b1; tick(); op_err = 1'b0;
        rd(W_STAT, v); chk("R6 busy cleared by error, R9 err", v, exp_stat(0,0,0,0,1,1));

        // R9 sticky flags
        wr(W_STAT, 32'h0);
        rd(W_STAT, v); chk("R9 write 0 no effect", v, 32'h3);
        wr(W_STAT, 32'h1);
        rd(W_STAT, v); chk("R9 clear eop only", v, 32'h2);
        wr(W_STAT, 32'h2);
        rd(W_STAT, v); chk("R9 clear err", v, 32'h0);

        // R10 collisions
        bus_addr = W_STAT; bus_wdata = 32'h1; bus_we = 1'b1; op_done = 1'b1;
        tick(); bus_we = 1'b0; op_done = 1'b0;
        rd(W_STAT, v); chk("R10 eop set wins", {31'b0, v[0]}, 32'h1);
        bus_addr = W_STAT; bus_wdata = 32'h8000; bus_we = 1'b1; opt_load_fail = 1'b1;
        tick(); bus_we = 1'b0; opt_load_fail = 1'b0;
        rd(W_STAT, v); chk("R10 optverr set wins", {31'b0, v[15]}, 32'h1);

        // R11 option validity error
        wr(W_STAT, 32'h0);
        rd(W_STAT, v); chk("R11 write 0 keeps", {31'b0, v[15]}, 32'h1);
        wr(W_STAT, 32'h8000);
        rd(W_STAT, v); chk("R11 cleared by 1", {31'b0, v[15]}, 32'h0);
        opt_load_fail = 1'b1; tick(); opt_load_fail = 1'b0;
        do_reset();
        rd(W_STAT, v); chk("R11 reset clears", v, 32'h0);
        opt_load_fail = 1'b1; tick(); opt_load_fail = 1'b0;
        rd(W_STAT, v); chk("R11 set again after reset", v, exp_stat(0,0,0,1,0,0));

        // R12 key and unmapped words
        rd(W_KEY, v); chk("R12 key word reads 0", v, 32'h0);
        rd(4'd7, v);  chk("R12 unmapped reads 0", v, 32'h0);

        // R7 R8 settings guard
        do_reset();
        wr(W_CTRL, 32'h0000_02A5);
        rd(W_CTRL, v); chk("R8 settings written", v, 32'h8000_02A5);
        set_exp = 10'h2A5;
        first_word = 1'b1; tick(); first_word = 1'b0;
        rd(W_STAT, v); chk("R7 cfg busy set", {31'b0, v[18]}, 32'h1);
        chk("R7 cfg_we low", {31'b0, cfg_we}, 32'h0);
        wr(W_CTRL, 32'h0000_015A);
        rd(W_CTRL, v); chk("R8 blocked write", {22'b0, v[9:0]}, {22'b0, set_exp});
        for (int t = 0; t < 16; t++) begin
            bit b;
            logic [31:0] nv;
            b = 1'($urandom);
            if (b) begin first_word = 1'b1; tick(); first_word = 1'b0; end
            else begin op_done = 1'b1; tick(); op_done = 1'b0; end
            chk("R7 cfg_we follows", {31'b0, cfg_we}, {31'b0, !b});
            nv = $urandom & 32'h7FFF_FFFF;
            wr(W_CTRL, nv);
            if (!b) set_exp = nv[9:0];
            rd(W_CTRL, v);
            chk("R8 settings guard", {22'b0, v[9:0]}, {22'b0, set_exp});
        end

        finished = 1'b1;
        report();
        $finish;
    end

endmodule